// File: doc/BRIEF.md
# UART Register and Interrupt Controller

This block is the software-facing control core of a 16550-style serial port. It sits between a byte-wide register bus and the serial shifters. On the transmit side it holds bytes in a holding path and offers them to the shifter through a ready/valid handshake. On the receive side it takes bytes from the shifter, and each byte carries its own parity, framing and break flags. The block also keeps the line status, the interrupt enables, a prioritized interrupt identification, and a modem control register and a modem status register.

The holding paths are either one byte deep or FIFOs of `FIFO_DEPTH` entries, chosen by a control bit. There is a single interrupt line, and the identification register names the highest-ranked pending cause. If software leaves all interrupt enables cleared, the line stays low and software polls the status registers instead. Register map (`addr`):
- 0: read pops the receive byte; write queues a transmit byte.
- 1: interrupt enables. Bit 0 is data-ready, bit 1 is transmit-empty, bit 2 is line-status and bit 3 is modem.
- 2: read returns the identification; write is the FIFO control. Bit 0 enables the FIFOs, bit 1 flushes receive and bit 2 flushes transmit.
- 3: line status.
- 4: modem control.
- 5: modem status.

Top module: `uart_regctl`

## Requirements
- R1: With FIFOs enabled (control bit 0 = 1), 16 transmit writes are held and a 17th is dropped. With FIFOs disabled, the path holds one byte and a second write is dropped. Held bytes leave on `tx_data` in write order.
- R2: Setting interrupt-enable bit 1 while the transmit path is empty raises `irq`, and the identification reads code 0010 in bits 3:0.
- R3: The first write to the transmit data register clears a pending transmit-empty cause. A read of the identification register that reports code 0010 also clears it.
- R4: Bytes on `rx_valid` are always accepted, with no enable. Reads of address 0 return them in arrival order. Line status bit 0 (data ready) is 1 while any byte is held and 0 once the last one is read. A read with nothing held returns 0.
- R5: Cause priority runs from line status (0110) to data ready (0100) to transmit empty (0010) to modem status (0000). The identification register reads {fifo_en, fifo_en, 00, code}.
- R6: Line status bits 2, 3 and 4 show the parity, framing and break flags of the byte at the head of the receive path, before that byte is read. A line status read hides them until the next byte reaches the head.
- R7: A byte that arrives while the receive path is full is discarded and sets overrun (line status bit 1). A line status read clears overrun.
- R8: Modem status bits 7:4 hold the `modem_in` levels. Bits 3:0 latch any change of each input. Reading the register clears bits 3:0, and a latched change raises the modem cause.
- R9: The modem control register reads back the value last written and drives `modem_out` directly.
- R10: `irq` is high exactly one cycle after an enabled cause is pending. With no cause pending, the identification reads code 0001.
- R11: FIFO control bit 1 empties the receive path and bit 2 empties the transmit path. Changing bit 0 empties both.
- R12: Line status bit 5 is 1 when the transmit path is empty. Bit 6 is 1 when the transmit path can take another byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (side effects apply at this edge) |
| addr | input | 3 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data, valid the cycle after `rd_en` |
| tx_data | output | 8 | Byte offered to the transmit shifter |
| tx_valid | output | 1 | Transmit byte available |
| tx_ready | input | 1 | Shifter takes the byte |
| rx_valid | input | 1 | Received byte strobe |
| rx_data | input | 8 | Received byte |
| rx_perr | input | 1 | Parity error of the received byte |
| rx_ferr | input | 1 | Framing error of the received byte |
| rx_brk | input | 1 | Break seen with the received byte |
| modem_in | input | 4 | Modem input levels |
| modem_out | output | 8 | Modem control levels |
| irq | output | 1 | Interrupt request |

## Verification
The receive path is tried with random bytes whose error flags are set in random combinations. This separates flags that belong to the head byte from flags that leak from later bytes, and shows whether a status read hides the flags only for the current head. Random mixes of receive pushes, status reads, data reads, transmit writes and drains are checked against a queue model with one-entry and sixteen-entry limits, so a wrong capacity or a wrong order shows up in the line status or in the data.

Directed cases check the rest:
- Filling past capacity tells a dropped byte apart from one that overwrites.
- Raising all four causes together and retiring them one by one tells each rank of the priority apart.
- Re-enabling the transmit interrupt while idle tells the arm-on-enable behaviour apart from arming only on a drain edge.

// File: rtl/uart_regctl_pkg.sv
`timescale 1ns/1ps
package uart_regctl_pkg;

  typedef enum logic [2:0] {
    A_DATA  = 3'd0,
    A_IEN   = 3'd1,
    A_IDENT = 3'd2,
    A_LSTAT = 3'd3,
    A_MCTL  = 3'd4,
    A_MSTAT = 3'd5
  } reg_addr_e;

  localparam logic [3:0] ID_LINE    = 4'b0110;
  localparam logic [3:0] ID_RXRDY   = 4'b0100;
  localparam logic [3:0] ID_TXEMPTY = 4'b0010;
  localparam logic [3:0] ID_MODEM   = 4'b0000;
  localparam logic [3:0] ID_NONE    = 4'b0001;

  typedef struct packed {
    logic       brk;
    logic       ferr;
    logic       perr;
    logic [7:0] data;
  } rx_entry_t;

  // cause index 0 ranks highest
  function automatic logic [3:0] cause_code(input int idx);
    case (idx)
      0:       return ID_LINE;
      1:       return ID_RXRDY;
      2:       return ID_TXEMPTY;
      default: return ID_MODEM;
    endcase
  endfunction

endpackage

// File: rtl/uart_byte_fifo.sv
`timescale 1ns/1ps
module uart_byte_fifo #(
  parameter int unsigned WIDTH = 8,
  parameter int unsigned DEPTH = 16,
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             flush,
  input  logic             single,
  input  logic             push,
  input  logic [WIDTH-1:0] push_data,
  input  logic             pop,
  output logic [WIDTH-1:0] head,
  output logic             empty,
  output logic             full
);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wptr, rptr;
  logic [CNT_W-1:0] count;
  logic             do_push, do_pop;

  assign empty   = (count == '0);
  assign full    = single ? !empty : (count == CNT_W'(DEPTH));
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  // storage without reset so it maps onto RAM
  always_ff @(posedge clk) begin
    if (do_push) mem[wptr] <= push_data;
  end

  assign head = mem[rptr];

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else begin
      if (do_push) wptr <= bump(wptr);
      if (do_pop)  rptr <= bump(rptr);
      case ({do_push, do_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: ;
      endcase
    end
  end

  AST_FULL_DROP: assert property (@(posedge clk) disable iff (rst)
    (push && full && !pop && !flush) |=> $stable(count)); // R1

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    count <= CNT_W'(DEPTH)); // R1

endmodule

// File: rtl/uart_irq_prio.sv
`timescale 1ns/1ps
module uart_irq_prio
  import uart_regctl_pkg::*;
#(
  parameter int unsigned NCAUSE = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NCAUSE-1:0] req,
  output logic [NCAUSE-1:0] grant,
  output logic [3:0]        code
);

  always_comb begin
    grant = '0;
    code  = ID_NONE;
    for (int i = int'(NCAUSE) - 1; i >= 0; i--) begin
      if (req[i]) begin
        grant    = '0;
        grant[i] = 1'b1;
        code     = cause_code(i);
      end
    end
  end

  AST_ONE_CAUSE: assert property (@(posedge clk) disable iff (rst)
    $onehot0(grant)); // R5

  AST_IDLE_CODE: assert property (@(posedge clk) disable iff (rst)
    (req == '0) |-> (code == ID_NONE)); // R10

endmodule

// File: rtl/uart_modem_regs.sv
`timescale 1ns/1ps
module uart_modem_regs #(
  parameter int unsigned NIN  = 4,
  parameter int unsigned NOUT = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NIN-1:0]  modem_in,
  input  logic            ctl_we,
  input  logic [NOUT-1:0] ctl_wdata,
  input  logic            stat_rd,
  output logic [NIN-1:0]  levels,
  output logic [NIN-1:0]  deltas,
  output logic [NOUT-1:0] ctl
);

  logic [NIN-1:0] prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev   <= modem_in;
      deltas <= '0;
      ctl    <= '0;
    end else begin
      prev   <= modem_in;
      // a fresh change wins over a clearing read in the same cycle
      deltas <= (stat_rd ? '0 : deltas) | (modem_in ^ prev);
      if (ctl_we) ctl <= ctl_wdata;
    end
  end

  assign levels = modem_in;

  AST_DELTA_LATCH: assert property (@(posedge clk) disable iff (rst)
    !$stable(modem_in) |=> (deltas != '0)); // R8

  AST_DELTA_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (stat_rd && $stable(modem_in)) |=> (deltas == '0)); // R8

endmodule

// File: rtl/uart_regctl.sv
`timescale 1ns/1ps
module uart_regctl
  import uart_regctl_pkg::*;
#(
  parameter int unsigned FIFO_DEPTH  = 16,
  parameter int unsigned MODEM_IN_W  = 4,
  parameter int unsigned MODEM_OUT_W = 8
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   wr_en,
  input  logic                   rd_en,
  input  logic [2:0]             addr,
  input  logic [7:0]             wdata,
  output logic [7:0]             rdata,
  output logic [7:0]             tx_data,
  output logic                   tx_valid,
  input  logic                   tx_ready,
  input  logic                   rx_valid,
  input  logic [7:0]             rx_data,
  input  logic                   rx_perr,
  input  logic                   rx_ferr,
  input  logic                   rx_brk,
  input  logic [MODEM_IN_W-1:0]  modem_in,
  output logic [MODEM_OUT_W-1:0] modem_out,
  output logic                   irq
);

  localparam int unsigned RXW    = $bits(rx_entry_t);
  localparam int unsigned NCAUSE = 4;

  // register bus decode
  logic wr_data, wr_ien, wr_fctl, wr_mctl;
  logic rd_data, rd_ident, rd_lstat, rd_mstat;
  assign wr_data  = wr_en && (addr == A_DATA);
  assign wr_ien   = wr_en && (addr == A_IEN);
  assign wr_fctl  = wr_en && (addr == A_IDENT);
  assign wr_mctl  = wr_en && (addr == A_MCTL);
  assign rd_data  = rd_en && (addr == A_DATA);
  assign rd_ident = rd_en && (addr == A_IDENT);
  assign rd_lstat = rd_en && (addr == A_LSTAT);
  assign rd_mstat = rd_en && (addr == A_MSTAT);

  logic [3:0] ier;
  logic       fifo_en, overrun, err_ack, thre_flag, tx_empty_q;
  logic       mode_chg, flush_rx, flush_tx;

  assign mode_chg = wr_fctl && (wdata[0] != fifo_en);
  assign flush_rx = wr_fctl && (wdata[1] || mode_chg);
  assign flush_tx = wr_fctl && (wdata[2] || mode_chg);

  // transmit holding path
  logic tx_empty, tx_full;
  uart_byte_fifo #(.WIDTH(8), .DEPTH(FIFO_DEPTH)) u_txq (
    .clk(clk), .rst(rst), .flush(flush_tx), .single(!fifo_en),
    .push(wr_data), .push_data(wdata), .pop(tx_ready),
    .head(tx_data), .empty(tx_empty), .full(tx_full)
  );
  assign tx_valid = !tx_empty;

  // receive path, error flags travel with each byte
  rx_entry_t rx_in, rx_head;
  logic      rx_empty, rx_full;
  assign rx_in = '{brk: rx_brk, ferr: rx_ferr, perr: rx_perr, data: rx_data};

  uart_byte_fifo #(.WIDTH(RXW), .DEPTH(FIFO_DEPTH)) u_rxq (
    .clk(clk), .rst(rst), .flush(flush_rx), .single(!fifo_en),
    .push(rx_valid), .push_data(rx_in), .pop(rd_data),
    .head(rx_head), .empty(rx_empty), .full(rx_full)
  );

  logic [2:0] head_err;
  assign head_err = (rx_empty || err_ack) ? 3'b000
                  : {rx_head.brk, rx_head.ferr, rx_head.perr};

  logic [7:0] lsr_val;
  assign lsr_val = {1'b0, !tx_full, tx_empty, head_err, overrun, !rx_empty};

  // modem registers
  logic [MODEM_IN_W-1:0]  m_lvl, m_dlt;
  logic [MODEM_OUT_W-1:0] m_ctl;
  uart_modem_regs #(.NIN(MODEM_IN_W), .NOUT(MODEM_OUT_W)) u_modem (
    .clk(clk), .rst(rst), .modem_in(modem_in),
    .ctl_we(wr_mctl), .ctl_wdata(wdata[MODEM_OUT_W-1:0]), .stat_rd(rd_mstat),
    .levels(m_lvl), .deltas(m_dlt), .ctl(m_ctl)
  );
  assign modem_out = m_ctl;

  // interrupt causes, index 0 ranks highest
  logic [NCAUSE-1:0] req, grant;
  logic [3:0]        code;
  assign req = { ier[3] && (m_dlt != '0),
                 ier[1] && thre_flag,
                 ier[0] && !rx_empty,
                 ier[2] && (overrun || (head_err != 3'b000)) };

  uart_irq_prio #(.NCAUSE(NCAUSE)) u_prio (
    .clk(clk), .rst(rst), .req(req), .grant(grant), .code(code)
  );

  logic tx_arm;
  assign tx_arm = (tx_empty && !tx_empty_q)
               || (wr_ien && wdata[1] && !ier[1] && tx_empty);

  always_ff @(posedge clk) begin
    if (rst) begin
      ier        <= '0;
      fifo_en    <= 1'b0;
      overrun    <= 1'b0;
      err_ack    <= 1'b0;
      thre_flag  <= 1'b0;
      tx_empty_q <= 1'b1;
      irq        <= 1'b0;
    end else begin
      if (wr_ien)  ier     <= wdata[3:0];
      if (wr_fctl) fifo_en <= wdata[0];
      overrun    <= (overrun && !rd_lstat) || (rx_valid && rx_full);
      if (flush_rx || rd_data)        err_ack <= 1'b0;
      else if (rd_lstat && !rx_empty) err_ack <= 1'b1;
      tx_empty_q <= tx_empty;
      if (wr_data)                    thre_flag <= 1'b0;
      else if (tx_arm)                thre_flag <= 1'b1;
      else if (rd_ident && grant[2])  thre_flag <= 1'b0;
      irq <= (req != '0);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else if (rd_en) begin
      case (addr)
        A_DATA:  rdata <= rx_empty ? 8'h00 : rx_head.data;
        A_IEN:   rdata <= {4'b0000, ier};
        A_IDENT: rdata <= {fifo_en, fifo_en, 2'b00, code};
        A_LSTAT: rdata <= lsr_val;
        A_MCTL:  rdata <= 8'(m_ctl);
        A_MSTAT: rdata <= 8'({m_lvl, m_dlt});
        default: rdata <= 8'h00;
      endcase
    end
  end

  AST_TXWR_CLEARS: assert property (@(posedge clk) disable iff (rst)
    wr_data |=> !thre_flag); // R3

  AST_ARM_ON_ENABLE: assert property (@(posedge clk) disable iff (rst)
    (wr_ien && wdata[1] && !ier[1] && tx_empty) |=> thre_flag); // R2

  AST_RX_OVERRUN: assert property (@(posedge clk) disable iff (rst)
    (rx_valid && rx_full) |=> overrun); // R7

  AST_QUIET_MASKED: assert property (@(posedge clk) disable iff (rst)
    (ier == 4'b0000) |=> !irq); // R10

endmodule

// File: tb/uart_regctl_test.sv
`timescale 1ns/1ps
module uart_regctl_test;

  logic       clk = 1'b0;
  logic       rst;
  logic       wr_en, rd_en, tx_ready, rx_valid, rx_perr, rx_ferr, rx_brk;
  logic [2:0] addr;
  logic [7:0] wdata, rdata, tx_data, rx_data, modem_out;
  logic       tx_valid, irq;
  logic [3:0] modem_in;

  uart_regctl uut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .tx_data(tx_data), .tx_valid(tx_valid),
    .tx_ready(tx_ready), .rx_valid(rx_valid), .rx_data(rx_data),
    .rx_perr(rx_perr), .rx_ferr(rx_ferr), .rx_brk(rx_brk),
    .modem_in(modem_in), .modem_out(modem_out), .irq(irq)
  );

  always #2.5 clk = ~clk;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // bench model
  logic [10:0] rxq[$];
  logic [7:0]  txq[$];
  bit          m_ovr, m_ack, m_fifo;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int lim();
    return m_fifo ? 16 : 1;
  endfunction

  function automatic logic [7:0] exp_lsr();
    logic [2:0] e;
    e = (rxq.size() == 0 || m_ack) ? 3'b000 : rxq[0][10:8];
    return {1'b0, txq.size() < lim(), txq.size() == 0, e, m_ovr, rxq.size() != 0};
  endfunction

  task automatic bus_wr(input logic [2:0] a, input logic [7:0] d);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic bus_rd(input logic [2:0] a, output logic [7:0] d);
    addr = a; rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    d = rdata;
  endtask

  task automatic rx_send(input logic [7:0] d, input logic [2:0] e);
    rx_data = d; {rx_brk, rx_ferr, rx_perr} = e; rx_valid = 1'b1;
    @(negedge clk);
    rx_valid = 1'b0;
    if (rxq.size() < lim()) rxq.push_back({e, d});
    else m_ovr = 1'b1;
  endtask

  task automatic tx_put(input logic [7:0] d);
    bus_wr(3'd0, d);
    if (txq.size() < lim()) txq.push_back(d);
  endtask

  task automatic tx_drain(input string req);
    logic [7:0] got[$];
    tx_ready = 1'b1;
    while (tx_valid) begin
      got.push_back(tx_data);
      @(negedge clk);
    end
    tx_ready = 1'b0;
    check(got.size() == txq.size(), req, got.size(), txq.size());
    for (int i = 0; i < got.size() && i < txq.size(); i++)
      check(got[i] == txq[i], req, got[i], txq[i]);
    txq.delete();
  endtask

  task automatic lsr_chk(input string req);
    logic [7:0] v;
    logic [7:0] e;
    e = exp_lsr();
    bus_rd(3'd3, v);
    check(v == e, req, v, e);
    m_ovr = 1'b0;
    if (rxq.size() != 0) m_ack = 1'b1;
  endtask

  task automatic data_chk(input string req);
    logic [7:0] v;
    logic [7:0] e;
    e = (rxq.size() == 0) ? 8'h00 : rxq[0][7:0];
    bus_rd(3'd0, v);
    check(v == e, req, v, e);
    if (rxq.size() != 0) void'(rxq.pop_front());
    m_ack = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual=%0h expected=%0h", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    logic [7:0] b;
    void'($urandom(32'h5A17));
    rst = 1'b1; wr_en = 0; rd_en = 0; addr = 0; wdata = 0; tx_ready = 0;
    rx_valid = 0; rx_data = 0; rx_perr = 0; rx_ferr = 0; rx_brk = 0; modem_in = 4'h0;
    m_ovr = 0; m_ack = 0; m_fifo = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // reset state
    check(irq == 1'b0, "R10", irq, 0);
    check(modem_out == 8'h00, "R9", modem_out, 0);
    lsr_chk("R12");
    bus_rd(3'd2, v); check(v == 8'h01, "R10", v, 8'h01);

    // R2: enable transmit-empty while idle
    bus_wr(3'd1, 8'h02); @(negedge clk);
    check(irq == 1'b1, "R2", irq, 1);
    bus_rd(3'd2, v); check(v == 8'h02, "R2", v, 8'h02);
    @(negedge clk);
    check(irq == 1'b0, "R3", irq, 0);

    // R3: re-arm then first data write clears
    bus_wr(3'd1, 8'h00); bus_wr(3'd1, 8'h02); @(negedge clk);
    check(irq == 1'b1, "R2", irq, 1);
    tx_put(8'h11); @(negedge clk);
    check(irq == 1'b0, "R3", irq, 0);
    bus_rd(3'd2, v); check(v == 8'h01, "R3", v, 8'h01);
    bus_wr(3'd1, 8'h00);

    // R1 single-byte mode: second write dropped
    tx_put(8'h22);
    lsr_chk("R12");
    tx_drain("R1");

    // R1 FIFO mode: 17 writes, 16 kept
    bus_wr(3'd2, 8'h01); m_fifo = 1;
    for (int i = 0; i < 17; i++) tx_put(8'($urandom));
    lsr_chk("R12");
    tx_drain("R1");

    // R6 directed: framing flag visible, then hidden by a status read
    rx_send(8'h5C, 3'b010);
    lsr_chk("R6");
    lsr_chk("R6");
    data_chk("R4");
    lsr_chk("R4");

    // R7: overrun on full receive path
    for (int i = 0; i < 17; i++) rx_send(8'($urandom), 3'b000);
    lsr_chk("R7");
    lsr_chk("R7");
    for (int i = 0; i < 17; i++) data_chk("R7");
    lsr_chk("R4");

    // R11: flushes
    for (int i = 0; i < 3; i++) rx_send(8'($urandom), 3'b001);
    bus_wr(3'd2, 8'h03); rxq.delete(); m_ack = 0;
    lsr_chk("R11");
    for (int i = 0; i < 4; i++) tx_put(8'($urandom));
    bus_wr(3'd2, 8'h05); txq.delete();
    check(tx_valid == 1'b0, "R11", tx_valid, 0);
    lsr_chk("R11");

    // R8: modem status levels and deltas
    bus_rd(3'd5, v);
    modem_in = 4'hA; @(negedge clk); @(negedge clk);
    bus_rd(3'd5, v); check(v == 8'hAA, "R8", v, 8'hAA);
    bus_rd(3'd5, v); check(v == 8'hA0, "R8", v, 8'hA0);

    // R9: modem control
    b = 8'($urandom);
    bus_wr(3'd4, b);
    bus_rd(3'd4, v); check(v == b, "R9", v, b);
    check(modem_out == b, "R9", modem_out, b);

    // R5: all four causes, retired in rank order
    rx_send(8'h3C, 3'b001);
    modem_in = 4'h5; @(negedge clk); @(negedge clk);
    bus_wr(3'd1, 8'h0F); @(negedge clk);
    check(irq == 1'b1, "R10", irq, 1);
    bus_rd(3'd2, v); check(v == 8'hC6, "R5", v, 8'hC6);
    lsr_chk("R6");
    bus_rd(3'd2, v); check(v == 8'hC4, "R5", v, 8'hC4);
    data_chk("R4");
    bus_rd(3'd2, v); check(v == 8'hC2, "R5", v, 8'hC2);
    bus_rd(3'd2, v); check(v == 8'hC0, "R5", v, 8'hC0);
    bus_rd(3'd5, v); check(v == 8'h5F, "R8", v, 8'h5F);
    bus_rd(3'd2, v); check(v == 8'hC1, "R5", v, 8'hC1);
    @(negedge clk);
    check(irq == 1'b0, "R10", irq, 0);
    bus_wr(3'd1, 8'h00);

    // random mix against the queue model
    for (int n = 0; n < 400; n++) begin
      case ($urandom_range(0, 5))
        0, 1: rx_send(8'($urandom),
                      {$urandom_range(0, 3) == 0, $urandom_range(0, 3) == 0, $urandom_range(0, 3) == 0});
        2: lsr_chk("R6");
        3: data_chk("R4");
        4: if ($urandom_range(0, 3) == 0) tx_drain("R1"); else tx_put(8'($urandom));
        default: begin
          bus_rd(3'd2, v); check(v == 8'hC1, "R10", v, 8'hC1);
          check(irq == 1'b0, "R10", irq, 0);
        end
      endcase
    end
    tx_drain("R1");

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule